// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one external bus cycle for every period of the bus clock E. Each E period lasts eight ticks of the faster system clock. An internal requester offers a 16-bit address, a direction flag and a write byte over a valid/ready channel. The block turns each accepted request into a bus cycle on a multiplexed port. The upper address byte goes out on its own pins. The lower byte shares an 8-bit port with the data, and an address strobe (AS) separates the two within the cycle, so an external latch can hold the low address.

Ticks are numbered 0 to 7 within the period. E is low for ticks 0 to 3 and high for ticks 4 to 7. AS is high for ticks 1 and 2. A request is taken only in tick 0. When nothing is offered, the block still runs an idle cycle: E and AS keep toggling, the direction pin reads "read", and the shared port is not driven. Read data comes back on a one-cycle pulse. The response channel has no back-pressure, so the consumer must take `rd_data` in the cycle where `rd_valid` is high. On the request side, the requester holds `req_valid` and the payload until it sees `req_ready` high at a clock edge. `req_ready` is high only during tick 0.

Top module: `mxbus_seq`

## Requirements
- R1: `bus_e` repeats with a period of eight clocks. It is low in ticks 0 to 3 and high in ticks 4 to 7, whether or not a request is pending.
- R2: `bus_as` is high only in ticks 1 and 2. It rises one clock after `bus_e` falls, and it falls one clock before `bus_e` rises.
- R3: In a read or write cycle, the shared port is driven (`bus_ad_oe`=1) with the low address byte `req_addr[7:0]` in ticks 1 to 3. The value does not change across the falling edge of AS.
- R4: `bus_addr_hi` (`req_addr[15:8]`) and `bus_rw` (1 = read, 0 = write) change only at the start of tick 1. They stay valid through tick 0 of the following period.
- R5: In a read cycle, the port is not driven in ticks 4 to 7 or in the following tick 0. The block captures the value on `bus_ad_in` during tick 7, which is the clock edge where E falls.
- R6: In a write cycle, the port carries the write byte in ticks 5, 6 and 7 and in the following tick 0.
- R7: After each read cycle, `rd_valid` is high for exactly one clock, in tick 0, with the captured byte on `rd_data`. At no other time is it high.
- R8: `req_ready` is high only in tick 0. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. Its values take effect from tick 1.
- R9: When no request is accepted in tick 0, the period is an idle cycle. E and AS follow R1 and R2, `bus_rw` is 1, `bus_addr_hi` keeps its last value, and the port is not driven.
- R10: Synchronous reset clears the tick counter to 0. It forces `bus_e`, `bus_as`, `bus_ad_oe` and `rd_valid` low, sets `bus_rw` to 1 and sets `bus_addr_hi` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, eight ticks per E period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | High in tick 0; request taken when both high |
| req_addr | input | 16 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read-response pulse |
| rd_data | output | 8 | Captured read byte |
| bus_e | output | 1 | Bus clock E |
| bus_as | output | 1 | Address strobe |
| bus_rw | output | 1 | Direction, 1 = read |
| bus_addr_hi | output | 8 | Upper address byte |
| bus_ad_out | output | 8 | Shared port output value |
| bus_ad_oe | output | 1 | Shared port output enable |
| bus_ad_in | input | 8 | Shared port input value |

## Verification
The properties assume that reset is held for at least two clocks. This keeps the strobe and clock edges that reset forces outside the timing checks. They also assume that the requester keeps the payload steady while `req_valid` waits for tick 0.

The stimulus meets both assumptions. Reset is asserted for three clocks at the start and three in the middle of the run. A request leaves the queue only after the reference model has seen it accepted. `bus_ad_in` changes randomly on every clock, so reads prove that only the tick-7 value is captured. Random gaps between requests produce idle periods and back-to-back cycles of both directions.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_t;

  // tick index of a point given in eighths of the E period
  function automatic int unsigned eighth_tick(input int unsigned eighths,
                                              input int unsigned tick_w);
    return (eighths << tick_w) / 8;
  endfunction

endpackage

// File: rtl/mxbus_phase.sv
module mxbus_phase #(
  parameter int TICK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic [TICK_W-1:0] ph_q,
  output logic [TICK_W-1:0] ph_n,
  output logic              e_q,
  output logic              as_q
);
  import mxbus_pkg::*;

  localparam logic [TICK_W-1:0] AS_RISE = TICK_W'(eighth_tick(1, TICK_W));
  localparam logic [TICK_W-1:0] AS_FALL = TICK_W'(eighth_tick(3, TICK_W));
  localparam logic [TICK_W-1:0] E_RISE  = TICK_W'(eighth_tick(4, TICK_W));

  // free-running tick counter, wraps once per E period
  assign ph_n = ph_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
      e_q  <= 1'b0;
      as_q <= 1'b0;
    end else begin
      ph_q <= ph_n;
      e_q  <= (ph_n >= E_RISE);
      as_q <= (ph_n >= AS_RISE) && (ph_n < AS_FALL);
    end
  end
endmodule

// File: rtl/mxbus_req.sv
module mxbus_req #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TICK_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [TICK_W-1:0]        ph_q,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        req_wdata,
  output mxbus_pkg::cyc_kind_t     kind_q,
  output mxbus_pkg::cyc_kind_t     kind_d,
  output logic [DATA_W-1:0]        alo_d,
  output logic [DATA_W-1:0]        wdat_d,
  output logic [ADDR_W-DATA_W-1:0] hi_q,
  output logic                     rw_q
);
  import mxbus_pkg::*;

  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] alo_q;
  logic [DATA_W-1:0] wdat_q;
  logic [HI_W-1:0]   hi_d;
  logic              rw_d;

  // the accept window is tick 0 only
  assign req_ready = (ph_q == '0);

  always_comb begin
    kind_d = kind_q;
    alo_d  = alo_q;
    wdat_d = wdat_q;
    hi_d   = hi_q;
    rw_d   = rw_q;
    if (req_ready) begin
      if (req_valid) begin
        kind_d = req_write ? CYC_WRITE : CYC_READ;
        alo_d  = req_addr[DATA_W-1:0];
        wdat_d = req_wdata;
        hi_d   = req_addr[ADDR_W-1:DATA_W];
        rw_d   = ~req_write;
      end else begin
        kind_d = CYC_IDLE;
        rw_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= CYC_IDLE;
      alo_q  <= '0;
      wdat_q <= '0;
      hi_q   <= '0;
      rw_q   <= 1'b1;
    end else begin
      kind_q <= kind_d;
      alo_q  <= alo_d;
      wdat_q <= wdat_d;
      hi_q   <= hi_d;
      rw_q   <= rw_d;
    end
  end
endmodule

// File: rtl/mxbus_port.sv
module mxbus_port #(
  parameter int DATA_W = 8,
  parameter int TICK_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TICK_W-1:0]    ph_q,
  input  logic [TICK_W-1:0]    ph_n,
  input  mxbus_pkg::cyc_kind_t kind_q,
  input  mxbus_pkg::cyc_kind_t kind_d,
  input  logic [DATA_W-1:0]    alo_d,
  input  logic [DATA_W-1:0]    wdat_d,
  input  logic [DATA_W-1:0]    ad_in,
  output logic [DATA_W-1:0]    ad_out,
  output logic                 ad_oe,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data
);
  import mxbus_pkg::*;

  localparam logic [TICK_W-1:0] AS_RISE = TICK_W'(eighth_tick(1, TICK_W));
  localparam logic [TICK_W-1:0] AS_FALL = TICK_W'(eighth_tick(3, TICK_W));
  localparam logic [TICK_W-1:0] WD_ON   = TICK_W'(eighth_tick(5, TICK_W));
  localparam logic [TICK_W-1:0] LAST    = {TICK_W{1'b1}};

  logic addr_win_n, data_win_n, oe_n;

  // windows are evaluated for the tick that starts at the next edge
  always_comb begin
    addr_win_n = (ph_n >= AS_RISE) && (ph_n <= AS_FALL);
    // write data: one eighth after E rises, to one eighth after E falls
    data_win_n = (ph_n >= WD_ON) || (ph_n < AS_RISE);
    oe_n = (addr_win_n && (kind_d != CYC_IDLE)) ||
           (data_win_n && (kind_d == CYC_WRITE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      ad_out   <= addr_win_n ? alo_d : wdat_d;
      ad_oe    <= oe_n;
      rd_valid <= (ph_q == LAST) && (kind_q == CYC_READ);
      if ((ph_q == LAST) && (kind_q == CYC_READ)) rd_data <= ad_in;
    end
  end
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TICK_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     bus_e,
  output logic                     bus_as,
  output logic                     bus_rw,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  output logic [DATA_W-1:0]        bus_ad_out,
  output logic                     bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_in
);
  import mxbus_pkg::*;

  logic [TICK_W-1:0] ph_q, ph_n;
  cyc_kind_t         kind_q, kind_d;
  logic [DATA_W-1:0] alo_d, wdat_d;

  mxbus_phase #(.TICK_W(TICK_W)) u_phase (
    .clk (clk), .rst (rst), .ph_q (ph_q), .ph_n (ph_n),
    .e_q (bus_e), .as_q (bus_as)
  );

  mxbus_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICK_W(TICK_W)) u_req (
    .clk (clk), .rst (rst), .ph_q (ph_q),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .req_write (req_write), .req_wdata (req_wdata),
    .kind_q (kind_q), .kind_d (kind_d), .alo_d (alo_d), .wdat_d (wdat_d),
    .hi_q (bus_addr_hi), .rw_q (bus_rw)
  );

  mxbus_port #(.DATA_W(DATA_W), .TICK_W(TICK_W)) u_port (
    .clk (clk), .rst (rst), .ph_q (ph_q), .ph_n (ph_n),
    .kind_q (kind_q), .kind_d (kind_d), .alo_d (alo_d), .wdat_d (wdat_d),
    .ad_in (bus_ad_in), .ad_out (bus_ad_out), .ad_oe (bus_ad_oe),
    .rd_valid (rd_valid), .rd_data (rd_data)
  );
endmodule

// File: rtl/mxbus_seq_chk.sv
module mxbus_seq_chk #(
  parameter int HI_W   = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_e,
  input logic              bus_as,
  input logic              bus_rw,
  input logic [HI_W-1:0]   bus_addr_hi,
  input logic [DATA_W-1:0] bus_ad_out,
  input logic              bus_ad_oe,
  input logic              req_ready,
  input logic              rd_valid
);
  // R2
  as_e_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_as && bus_e));
  // R2
  as_after_efall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_e) |=> $rose(bus_as));
  // R2
  e_after_asfall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_as) |=> $rose(bus_e));
  // R2
  as_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_as) |=> bus_as ##1 !bus_as);
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_as) |-> ($stable(bus_ad_out) && $stable(bus_ad_oe)));
  // R4
  hi_rw_steady_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_e) |-> ($stable(bus_rw) && $stable(bus_addr_hi)));
  // R5
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_e && bus_rw) |-> !bus_ad_oe);
  // R7
  rdv_at_efall_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $fell(bus_e));
  // R7
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  // R8
  ready_window_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!bus_e && !bus_as));
endmodule

bind mxbus_seq mxbus_seq_chk #(.HI_W(ADDR_W-DATA_W), .DATA_W(DATA_W)) u_chk (
  .clk (clk), .rst (rst), .bus_e (bus_e), .bus_as (bus_as), .bus_rw (bus_rw),
  .bus_addr_hi (bus_addr_hi), .bus_ad_out (bus_ad_out), .bus_ad_oe (bus_ad_oe),
  .req_ready (req_ready), .rd_valid (rd_valid)
);

// File: tb/mxbus_seq_tb_top.sv
module mxbus_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef struct {
    logic [AW-1:0] a;
    logic          w;
    logic [DW-1:0] d;
  } rq_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, req_valid, req_ready, req_write, rd_valid;
  logic bus_e, bus_as, bus_rw, bus_ad_oe;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rd_data, bus_ad_out, bus_ad_in;
  logic [AW-DW-1:0] bus_addr_hi;

  mxbus_seq #(.ADDR_W(AW), .DATA_W(DW), .TICK_W(3)) dut_i (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_write (req_write), .req_wdata (req_wdata),
    .rd_valid (rd_valid), .rd_data (rd_data), .bus_e (bus_e), .bus_as (bus_as),
    .bus_rw (bus_rw), .bus_addr_hi (bus_addr_hi), .bus_ad_out (bus_ad_out),
    .bus_ad_oe (bus_ad_oe), .bus_ad_in (bus_ad_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 read, 2 write
  int m_tick, m_kind;
  logic m_rw, m_rdv;
  logic [DW-1:0] m_hi, m_alo, m_wd, m_rdd;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_tick = 0; m_kind = 0; m_rw = 1'b1; m_rdv = 1'b0;
    m_hi = '0; m_alo = '0; m_wd = '0; m_rdd = '0;
  endtask

  task automatic compare(input bit in_rst);
    bit e_x, as_x, oe_x, in_addr;
    string tp;
    e_x  = (m_tick >= 4);
    as_x = (m_tick == 1) || (m_tick == 2);
    in_addr = (m_tick >= 1) && (m_tick <= 3);
    oe_x = (in_addr && m_kind != 0) || (m_kind == 2 && (m_tick >= 5 || m_tick == 0));
    if (in_rst)            tp = "R10";
    else if (m_kind == 0)  tp = "R9";
    else if (in_addr)      tp = "R3";
    else if (m_kind == 1)  tp = "R5";
    else                   tp = "R6";
    chk(in_rst ? "R10" : "R1", "bus_e", 32'(bus_e), 32'(e_x));
    chk(in_rst ? "R10" : "R2", "bus_as", 32'(bus_as), 32'(as_x));
    chk(in_rst ? "R10" : "R4", "bus_rw", 32'(bus_rw), 32'(m_rw));
    chk(in_rst ? "R10" : "R4", "bus_addr_hi", 32'(bus_addr_hi), 32'(m_hi));
    chk(tp, "bus_ad_oe", 32'(bus_ad_oe), 32'(oe_x));
    if (oe_x)
      chk(tp, "bus_ad_out", 32'(bus_ad_out), in_addr ? 32'(m_alo) : 32'(m_wd));
    chk("R8", "req_ready", 32'(req_ready), 32'(m_tick == 0));
    chk(in_rst ? "R10" : "R7", "rd_valid", 32'(rd_valid), 32'(m_rdv));
    if (m_rdv) chk("R5", "rd_data", 32'(rd_data), 32'(m_rdd));
  endtask

  task automatic model_step(input logic v, input logic [AW-1:0] a, input logic w,
                            input logic [DW-1:0] d, input logic [DW-1:0] adin,
                            output bit acc);
    acc = (m_tick == 0) && v;
    m_rdv = (m_tick == 7) && (m_kind == 1);
    if (m_rdv) m_rdd = adin;
    if (m_tick == 0) begin
      if (v) begin
        m_kind = w ? 2 : 1; m_alo = a[DW-1:0]; m_wd = d;
        m_hi = a[AW-1:DW]; m_rw = ~w;
      end else begin
        m_kind = 0; m_rw = 1'b1;
      end
    end
    m_tick = (m_tick + 1) % 8;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    rq_t q[$];
    bit acc, rst_nx;
    int gap, cyc, drain;
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    req_wdata = '0; bus_ad_in = '0;
    model_reset();
    // boundary addresses first, then a random mix of both directions
    q.push_back('{a: 16'h0000, w: 1'b0, d: 8'h00});
    q.push_back('{a: 16'hFFFF, w: 1'b1, d: 8'hA5});
    q.push_back('{a: 16'hFFFF, w: 1'b0, d: 8'h00});
    q.push_back('{a: 16'h0000, w: 1'b1, d: 8'h5A});
    q.push_back('{a: 16'h00FF, w: 1'b1, d: 8'hFF});
    q.push_back('{a: 16'hFF00, w: 1'b0, d: 8'h00});
    for (int i = 0; i < 60; i++)
      q.push_back('{a: 16'($urandom), w: 1'($urandom), d: 8'($urandom)});
    acc = 0; gap = 0; cyc = 0; drain = 0;
    while (drain < 24) begin
      @(negedge clk);
      compare(rst);
      if (acc) begin
        void'(q.pop_front());
        gap = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 20) : 0;
      end
      if (gap > 0) gap--;
      rst_nx = (cyc < 3) || (cyc >= 400 && cyc < 403);
      req_valid = (q.size() > 0) && (gap == 0);
      if (q.size() > 0) begin
        req_addr = q[0].a; req_write = q[0].w; req_wdata = q[0].d;
      end
      bus_ad_in = 8'($urandom);
      rst = rst_nx;
      if (rst_nx) begin
        model_reset(); acc = 0;
      end else begin
        model_step(req_valid, req_addr, req_write, req_wdata, bus_ad_in, acc);
      end
      cyc++;
      if (q.size() == 0) drain++;
    end
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule